// File: doc/BRIEF.md
# Channelised Ring Pointer Register Block

This block holds the producer and consumer indices for a set of request/response ring pairs. The rings themselves live in host memory. Each channel owns a pair of rings. The host fills the request ring and drains the response ring. The device drains the request ring and fills the response ring. The block keeps the four indices of every channel and lets the host reach them through a small memory-mapped register port. A read returns data in the same cycle. A write takes effect at the next clock edge.

Each channel has its own 4 KB window. The device side names one channel at a time. For that channel the block supplies the host address of the request element at the consume index and the address of the response slot at the produce index. It also reports whether requests are pending and whether the response ring is full. The device consumes a request with a pop strobe and posts a response with a push strobe.

Every channel's requests and responses share one contiguous memory chunk. Requests start at the beginning of the chunk and responses occupy its top. An accepted push into an empty response ring produces a one-cycle interrupt pulse tagged with the channel. A push can also carry a per-request force flag. When a global enable is set, that flag produces the pulse even though the ring already holds entries.

Top module: `ring_ptr_top`

## Requirements
- R1: After reset every index of every channel is 0, `msi_o` is low, `req_avail_o` is low and `rsp_full_o` is low.
- R2: The word at offset 0x0 is the request consume index and the word at 0x4 is the request produce index. The word at 0x8 is the response consume index and the word at 0xC is the response produce index. Each index is PTR_W bits, zero-extended on read. A write keeps only the low PTR_W data bits.
- R3: Host writes to offsets 0x0 and 0xC change nothing. Any offset other than those four reads as 0, and a write to it changes nothing.
- R4: Address bits [ADDR_W-1:12] pick the channel, and each channel's indices are independent. The same channel number appears on `msi_ch_o` with its interrupt.
- R5: A pop advances the request consume index of `dev_ch_i` by one. A pop is ignored when that ring is empty. `req_avail_o` is high exactly when the two request indices differ.
- R6: A push advances the response produce index by one unless the ring is full. The ring is full when the produce index plus one equals the consume index. A push into a full ring is dropped, and `rsp_full_o` shows the full condition.
- R7: `req_elem_addr_o` equals the channel base plus the request consume index times REQ_ELEM_B (64).
- R8: `rsp_elem_addr_o` equals the channel base plus CHUNK_B minus DEPTH*RSP_ELEM_B plus the response produce index times RSP_ELEM_B. With the defaults this is base + 3968 + 8 * index.
- R9: An accepted push into an empty response ring drives `msi_o` high for exactly the following cycle, with `msi_ch_o` set to the pushing channel.
- R10: A push into a non-empty ring raises the interrupt only when both `rsp_force_i` and `force_en_i` are high. A push dropped because the ring is full never raises it.
- R11: All indices wrap modulo DEPTH (a power of two). Advancing from DEPTH-1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | ADDR_W | Host byte address: channel in the upper bits, 12-bit window offset below |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for `reg_addr_i` (combinational) |
| ring_base_i | input | NUM_CH*AW | Memory chunk base per channel, channel 0 in the low bits |
| force_en_i | input | 1 | Lets the per-request force flag raise interrupts |
| dev_ch_i | input | CH_W | Channel served by the device side |
| req_pop_i | input | 1 | Device consumes one request |
| rsp_push_i | input | 1 | Device posts one response |
| rsp_force_i | input | 1 | Force flag of the request whose response is being posted |
| req_avail_o | output | 1 | Requests pending on `dev_ch_i` |
| rsp_full_o | output | 1 | Response ring of `dev_ch_i` is full |
| req_elem_addr_o | output | AW | Host address of the next request element |
| rsp_elem_addr_o | output | AW | Host address of the next response slot |
| msi_o | output | 1 | One-cycle interrupt pulse |
| msi_ch_o | output | CH_W | Channel that raised `msi_o` |

## Verification
The hardest state to reach is a full response ring followed by a wrap of the produce index. This requires DEPTH-1 accepted pushes with no host drain, then a host write that empties the ring with both indices at DEPTH-1. The bench drives the push strobe in a counted loop on one channel until `rsp_full_o` rises. It then tries one extra push and checks that neither the index nor the interrupt moves. After that it writes the consume index to 15 and pushes once more. That push must wrap the index to 0 and must raise the interrupt, because the ring was empty. The request side is wrapped the same way: the host sets the produce index behind the consume index, and the bench pops DEPTH-1 times.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int unsigned WIN_BITS = 12;

  typedef enum logic [1:0] {
    SEL_REQ_HEAD = 2'd0,
    SEL_REQ_TAIL = 2'd1,
    SEL_RSP_HEAD = 2'd2,
    SEL_RSP_TAIL = 2'd3
  } ptr_sel_e;

  // word-aligned and inside the first 16 bytes of the window
  function automatic logic off_mapped(input logic [WIN_BITS-1:0] off);
    return (off[WIN_BITS-1:4] == '0) && (off[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/ring_ptr_chan.sv
module ring_ptr_chan
  import ring_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  ptr_sel_e         host_sel_i,
  input  logic [PTR_W-1:0] host_wdata_i,
  input  logic             pop_i,
  input  logic             push_i,
  output logic [PTR_W-1:0] req_head_o,
  output logic [PTR_W-1:0] req_tail_o,
  output logic [PTR_W-1:0] rsp_head_o,
  output logic [PTR_W-1:0] rsp_tail_o,
  output logic             req_avail_o,
  output logic             rsp_full_o,
  output logic             rsp_empty_o,
  output logic             push_ok_o
);
  logic [PTR_W-1:0] req_head_q, req_tail_q, rsp_head_q, rsp_tail_q;
  logic [PTR_W-1:0] rsp_tail_nxt;
  logic             pop_ok;

  assign rsp_tail_nxt = rsp_tail_q + 1'b1;
  assign req_avail_o  = (req_head_q != req_tail_q);
  assign rsp_empty_o  = (rsp_head_q == rsp_tail_q);
  assign rsp_full_o   = (rsp_tail_nxt == rsp_head_q);
  assign pop_ok       = pop_i && req_avail_o;
  assign push_ok_o    = push_i && !rsp_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_head_q <= '0;
      req_tail_q <= '0;
      rsp_head_q <= '0;
      rsp_tail_q <= '0;
    end else begin
      if (pop_ok)    req_head_q <= req_head_q + 1'b1;
      if (push_ok_o) rsp_tail_q <= rsp_tail_nxt;
      if (host_we_i && host_sel_i == SEL_REQ_TAIL) req_tail_q <= host_wdata_i;
      if (host_we_i && host_sel_i == SEL_RSP_HEAD) rsp_head_q <= host_wdata_i;
    end
  end

  assign req_head_o = req_head_q;
  assign req_tail_o = req_tail_q;
  assign rsp_head_o = rsp_head_q;
  assign rsp_tail_o = rsp_tail_q;

  // R5
  req_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && req_head_q == req_tail_q) |=> $stable(req_head_q));
  // R3
  req_head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(req_head_q));
  // R3
  rsp_tail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(rsp_tail_q));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && rsp_full_o) |=> $stable(rsp_tail_q));
endmodule

// File: rtl/ring_addr_calc.sv
module ring_addr_calc #(
  parameter int unsigned AW         = 32,
  parameter int unsigned PTR_W      = 4,
  parameter int unsigned REQ_ELEM_B = 64,
  parameter int unsigned RSP_ELEM_B = 8,
  parameter int unsigned CHUNK_B    = 4096
) (
  input  logic [AW-1:0]    base_i,
  input  logic [PTR_W-1:0] req_idx_i,
  input  logic [PTR_W-1:0] rsp_idx_i,
  output logic [AW-1:0]    req_addr_o,
  output logic [AW-1:0]    rsp_addr_o
);
  localparam int unsigned DEPTH   = 2 ** PTR_W;
  localparam int unsigned RSP_OFF = CHUNK_B - DEPTH * RSP_ELEM_B;

  // response ring is placed at the top of the chunk
  assign req_addr_o = base_i + AW'(req_idx_i) * AW'(REQ_ELEM_B);
  assign rsp_addr_o = base_i + AW'(RSP_OFF) + AW'(rsp_idx_i) * AW'(RSP_ELEM_B);
endmodule

// File: rtl/ring_msi_gen.sv
module ring_msi_gen #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_ok_i,
  input  logic            was_empty_i,
  input  logic            force_i,
  input  logic            force_en_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            msi_o,
  output logic [CH_W-1:0] msi_ch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msi_o    <= 1'b0;
      msi_ch_o <= '0;
    end else begin
      msi_o <= push_ok_i && (was_empty_i || (force_i && force_en_i));
      if (push_ok_i) msi_ch_o <= ch_i;
    end
  end

  // R10
  msi_force_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_o && !$past(was_empty_i)) |-> $past(force_i && force_en_i));
endmodule

// File: rtl/ring_ptr_top.sv
module ring_ptr_top
  import ring_ptr_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned REQ_ELEM_B = 64,
  parameter int unsigned RSP_ELEM_B = 8,
  parameter int unsigned CHUNK_B    = 4096,
  localparam int unsigned PTR_W     = $clog2(DEPTH),
  localparam int unsigned CH_W      = $clog2(NUM_CH),
  localparam int unsigned ADDR_W    = WIN_BITS + CH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_CH*AW-1:0] ring_base_i,
  input  logic                 force_en_i,
  input  logic [CH_W-1:0]      dev_ch_i,
  input  logic                 req_pop_i,
  input  logic                 rsp_push_i,
  input  logic                 rsp_force_i,
  output logic                 req_avail_o,
  output logic                 rsp_full_o,
  output logic [AW-1:0]        req_elem_addr_o,
  output logic [AW-1:0]        rsp_elem_addr_o,
  output logic                 msi_o,
  output logic [CH_W-1:0]      msi_ch_o
);
  logic [CH_W-1:0]     win_ch;
  logic [WIN_BITS-1:0] win_off;
  logic                hit;
  ptr_sel_e            sel;
  logic                unused_wdata;

  logic [PTR_W-1:0] req_head [NUM_CH];
  logic [PTR_W-1:0] req_tail [NUM_CH];
  logic [PTR_W-1:0] rsp_head [NUM_CH];
  logic [PTR_W-1:0] rsp_tail [NUM_CH];
  logic [NUM_CH-1:0] avail_v, full_v, empty_v, push_ok_v;

  assign win_ch       = reg_addr_i[ADDR_W-1:WIN_BITS];
  assign win_off      = reg_addr_i[WIN_BITS-1:0];
  assign hit          = off_mapped(win_off) && (32'(win_ch) < NUM_CH);
  assign sel          = ptr_sel_e'(win_off[3:2]);
  assign unused_wdata = ^reg_wdata_i[31:PTR_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ring_ptr_chan #(.PTR_W(PTR_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .host_we_i   (reg_we_i && hit && (win_ch == CH_W'(c))),
      .host_sel_i  (sel),
      .host_wdata_i(reg_wdata_i[PTR_W-1:0]),
      .pop_i       (req_pop_i && (dev_ch_i == CH_W'(c))),
      .push_i      (rsp_push_i && (dev_ch_i == CH_W'(c))),
      .req_head_o  (req_head[c]),
      .req_tail_o  (req_tail[c]),
      .rsp_head_o  (rsp_head[c]),
      .rsp_tail_o  (rsp_tail[c]),
      .req_avail_o (avail_v[c]),
      .rsp_full_o  (full_v[c]),
      .rsp_empty_o (empty_v[c]),
      .push_ok_o   (push_ok_v[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_REQ_HEAD: reg_rdata_o = 32'(req_head[win_ch]);
        SEL_REQ_TAIL: reg_rdata_o = 32'(req_tail[win_ch]);
        SEL_RSP_HEAD: reg_rdata_o = 32'(rsp_head[win_ch]);
        SEL_RSP_TAIL: reg_rdata_o = 32'(rsp_tail[win_ch]);
        default:      reg_rdata_o = '0;
      endcase
    end
  end

  assign req_avail_o = avail_v[dev_ch_i];
  assign rsp_full_o  = full_v[dev_ch_i];

  ring_addr_calc #(
    .AW(AW), .PTR_W(PTR_W), .REQ_ELEM_B(REQ_ELEM_B),
    .RSP_ELEM_B(RSP_ELEM_B), .CHUNK_B(CHUNK_B)
  ) u_addr (
    .base_i    (ring_base_i[dev_ch_i*AW +: AW]),
    .req_idx_i (req_head[dev_ch_i]),
    .rsp_idx_i (rsp_tail[dev_ch_i]),
    .req_addr_o(req_elem_addr_o),
    .rsp_addr_o(rsp_elem_addr_o)
  );

  ring_msi_gen #(.CH_W(CH_W)) u_msi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_ok_i  (push_ok_v[dev_ch_i]),
    .was_empty_i(empty_v[dev_ch_i]),
    .force_i    (rsp_force_i),
    .force_en_i (force_en_i),
    .ch_i       (dev_ch_i),
    .msi_o      (msi_o),
    .msi_ch_o   (msi_ch_o)
  );

  // R10
  msi_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |-> ($past(rsp_push_i) && !$past(rsp_full_o)));
  // R9
  msi_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |-> (msi_ch_o == $past(dev_ch_i)));
endmodule

// File: tb/tb_ring_ptr_top.sv
`timescale 1ns/1ps
module tb_ring_ptr_top;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned AW     = 32;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned RSP_BASE_OFF = 4096 - 16 * 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic [NUM_CH*AW-1:0] ring_base_i;
  logic              force_en_i = 1'b0;
  logic [CH_W-1:0]   dev_ch_i = '0;
  logic              req_pop_i = 1'b0;
  logic              rsp_push_i = 1'b0;
  logic              rsp_force_i = 1'b0;
  logic              req_avail_o, rsp_full_o, msi_o;
  logic [AW-1:0]     req_elem_addr_o, rsp_elem_addr_o;
  logic [CH_W-1:0]   msi_ch_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [AW-1:0] base_of(input int ch);
    return 32'h1000_0000 * (ch + 1);
  endfunction

  assign ring_base_i = {base_of(3), base_of(2), base_of(1), base_of(0)};

  ring_ptr_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int ch, input logic [11:0] off, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = {CH_W'(ch), off};
    reg_wdata_i = d;
    reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic host_rd(input int ch, input logic [11:0] off, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = {CH_W'(ch), off};
    #1 d = reg_rdata_o;
  endtask

  // one strobe cycle; returns at the negedge after the capturing edge
  task automatic dev_op(input int ch, input bit pop, input bit push, input bit frc);
    @(negedge clk_i);
    dev_ch_i = CH_W'(ch);
    req_pop_i = pop;
    rsp_push_i = push;
    rsp_force_i = frc;
    @(negedge clk_i);
    req_pop_i = 1'b0;
    rsp_push_i = 1'b0;
    rsp_force_i = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  ch;
    logic [11:0] off;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 12'h000, 32'd0,  32'd0, 8'd1},  // R1
    '{1'b1, 2'd0, 12'h004, 32'd5,  32'd0, 8'd2},  // R2
    '{1'b0, 2'd0, 12'h004, 32'd0,  32'd5, 8'd2},
    '{1'b1, 2'd0, 12'h000, 32'd7,  32'd0, 8'd3},  // R3
    '{1'b0, 2'd0, 12'h000, 32'd0,  32'd0, 8'd3},
    '{1'b1, 2'd1, 12'h008, 32'd3,  32'd0, 8'd4},  // R4
    '{1'b0, 2'd1, 12'h008, 32'd0,  32'd3, 8'd4},
    '{1'b0, 2'd0, 12'h008, 32'd0,  32'd0, 8'd4},
    '{1'b1, 2'd2, 12'h004, 32'h13, 32'd0, 8'd2},  // truncation
    '{1'b0, 2'd2, 12'h004, 32'd0,  32'd3, 8'd2},
    '{1'b1, 2'd0, 12'h010, 32'd9,  32'd0, 8'd3},
    '{1'b0, 2'd0, 12'h010, 32'd0,  32'd0, 8'd3},
    '{1'b1, 2'd3, 12'h00C, 32'd4,  32'd0, 8'd3},
    '{1'b0, 2'd3, 12'h00C, 32'd0,  32'd0, 8'd3}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    int head;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, R7 R8 addresses at index 0
    @(negedge clk_i);
    chk("R1 msi", 32'(msi_o), 0);
    chk("R1 avail", 32'(req_avail_o), 0);
    chk("R1 full", 32'(rsp_full_o), 0);
    chk("R7 req addr idx0", req_elem_addr_o, base_of(0));
    chk("R8 rsp addr idx0", rsp_elem_addr_o, base_of(0) + RSP_BASE_OFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) host_wr(VEC[i].ch, VEC[i].off, VEC[i].data);
      else begin
        host_rd(VEC[i].ch, VEC[i].off, rd);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R5 pops on ch0 (tail 5)
    dev_ch_i = '0;
    #1 chk("R5 avail", 32'(req_avail_o), 1);
    for (int i = 1; i <= 5; i++) begin
      dev_op(0, 1'b1, 1'b0, 1'b0);
      chk("R7 req addr", req_elem_addr_o, base_of(0) + 32'(i) * 64);
    end
    chk("R5 drained", 32'(req_avail_o), 0);
    dev_op(0, 1'b1, 1'b0, 1'b0);
    host_rd(0, 12'h000, rd);
    chk("R5 pop empty", rd, 5);

    // R9 push into empty ring
    dev_op(0, 1'b0, 1'b1, 1'b0);
    chk("R9 msi", 32'(msi_o), 1);
    chk("R9 msi ch", 32'(msi_ch_o), 0);
    chk("R8 rsp addr", rsp_elem_addr_o, base_of(0) + RSP_BASE_OFF + 8);
    @(negedge clk_i);
    chk("R9 single pulse", 32'(msi_o), 0);
    // R10 non-empty, no force
    dev_op(0, 1'b0, 1'b1, 1'b0);
    chk("R10 no force", 32'(msi_o), 0);
    dev_op(0, 1'b0, 1'b1, 1'b1);
    chk("R10 force disabled", 32'(msi_o), 0);
    force_en_i = 1'b1;
    dev_op(0, 1'b0, 1'b1, 1'b1);
    chk("R10 force enabled", 32'(msi_o), 1);
    force_en_i = 1'b0;

    // R6 fill to tail 15
    for (int i = 4; i < 15; i++) dev_op(0, 1'b0, 1'b1, 1'b0);
    chk("R6 full", 32'(rsp_full_o), 1);
    force_en_i = 1'b1;
    dev_op(0, 1'b0, 1'b1, 1'b1);
    chk("R10 rejected no msi", 32'(msi_o), 0);
    force_en_i = 1'b0;
    host_rd(0, 12'h00C, rd);
    chk("R6 tail held", rd, 15);

    // R11 response wrap
    host_wr(0, 12'h008, 32'd15);
    dev_op(0, 1'b0, 1'b1, 1'b0);
    chk("R11 wrap msi", 32'(msi_o), 1);
    host_rd(0, 12'h00C, rd);
    chk("R11 rsp tail wrap", rd, 0);

    // R11 request wrap: head 5, tail 4 -> 15 pending
    host_wr(0, 12'h004, 32'd4);
    head = 5;
    for (int i = 0; i < 15; i++) dev_op(0, 1'b1, 1'b0, 1'b0);
    host_rd(0, 12'h000, rd);
    chk("R11 req head wrap", rd, 4);
    chk("R11 drained", 32'(req_avail_o), 0);

    // R4 channel tag on interrupt
    dev_op(3, 1'b0, 1'b1, 1'b0);
    chk("R4 msi ch3", 32'(msi_ch_o), 3);
    chk("R4 msi ch3 pulse", 32'(msi_o), 1);
    chk("R8 ch3 rsp addr", rsp_elem_addr_o, base_of(3) + RSP_BASE_OFF + 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule